// File: doc/BRIEF.md
# Multi-Core Wired-OR GPIO Combiner

This block merges the pin requests of several processor cores onto one shared 32-pin port. Each core owns an output latch and a direction register and can also present auxiliary output vectors from its own internal units, such as a video or counter unit. A core's contribution to the port is the OR of its latch and its auxiliary vector, masked by its direction register. The contributions of all cores are ORed together, so any core can drive any pin at any time with no arbitration and no electrical contention.

The pin value and output-enable vectors are registered. Each core writes its registers through its own masked write ports. A write mask lets software change a group of bits and leave the others alone. Each core reads back only its own latch.

A core whose enable flag is low has no effect on the port, as if its direction register were clear. When a core's enable rises, the core is starting, and both of its registers clear.

Top module: `gpio_wor_combiner`

## Requirements
- R1: After an active-low reset, pin_oe_o, pin_val_o and every core's out_rdata_o are all zero.
- R2: A latch write by an enabled core sets bit k of the latch to out_wdata_i bit k where out_wmask_i bit k is 1 and keeps bit k where the mask bit is 0; the new value appears on that core's out_rdata_o one clock later.
- R3: A direction write by an enabled core updates the direction register under dir_wmask_i in the same masked way.
- R4: A core's out_rdata_o shows only its own latch. Neither the auxiliary vector nor the pin state of the port appears in it.
- R5: An enabled core contributes (latch OR aux_out_i) AND direction to the pin values. A latch or aux bit whose direction bit is clear has no effect.
- R6: Bit k of pin_oe_o is the OR over enabled cores of direction bit k. Bit k of pin_val_o is the OR over cores of their gated contributions to pin k.
- R7: A core whose core_en_i bit is low adds nothing to pin_oe_o or pin_val_o, whatever its registers and aux inputs hold.
- R8: Register writes from a core whose enable is low are ignored, and its latch keeps its value.
- R9: In the cycle where a core's enable rises from low to high, its latch and direction register clear to zero, and any write presented in that cycle is discarded.
- R10: pin_oe_o and pin_val_o reflect the register writes, enables and aux inputs of the previous clock, updating exactly one clock after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_en_i | input | N_CORES | Per-core enable flag |
| out_we_i | input | N_CORES | Per-core latch write strobe |
| out_wdata_i | input | N_CORES x N_PINS | Per-core latch write data |
| out_wmask_i | input | N_CORES x N_PINS | Per-core latch bit write mask |
| dir_we_i | input | N_CORES | Per-core direction write strobe |
| dir_wdata_i | input | N_CORES x N_PINS | Per-core direction write data |
| dir_wmask_i | input | N_CORES x N_PINS | Per-core direction bit write mask |
| aux_out_i | input | N_CORES x N_PINS | Per-core auxiliary output vector |
| out_rdata_o | output | N_CORES x N_PINS | Per-core latch readback |
| pin_oe_o | output | N_PINS | Registered pin output enables |
| pin_val_o | output | N_PINS | Registered pin output values |

## Verification
A core start and a register write from the same core can land in the same cycle. A core being disabled and another core driving the same pin can also coincide. Directed steps raise a core's enable together with a full-mask write, and the bench expects a cleared latch and no contribution from that core. Random phases toggle enables while writes and aux vectors vary on every core, so many cores overlap on the same pins. A bench model predicts every pin and readback value one clock ahead, and each step is judged against that model.

// File: rtl/gpio_wor_pkg.sv
package gpio_wor_pkg;
  // masked bitwise update shared by both per-core registers
  function automatic logic [31:0] mask_merge(input logic [31:0] cur,
                                             input logic [31:0] wdata,
                                             input logic [31:0] wmask);
    return (cur & ~wmask) | (wdata & wmask);
  endfunction
endpackage

// File: rtl/gpio_core_slot.sv
module gpio_core_slot
  import gpio_wor_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              out_we_i,
  input  logic [N_PINS-1:0] out_wdata_i,
  input  logic [N_PINS-1:0] out_wmask_i,
  input  logic              dir_we_i,
  input  logic [N_PINS-1:0] dir_wdata_i,
  input  logic [N_PINS-1:0] dir_wmask_i,
  input  logic [N_PINS-1:0] aux_i,
  output logic [N_PINS-1:0] out_q_o,
  output logic [N_PINS-1:0] oe_nxt_o,
  output logic [N_PINS-1:0] val_nxt_o
);
  logic              en_q;
  logic              start;
  logic [N_PINS-1:0] out_q, out_d, dir_q, dir_d;

  assign start = en_i & ~en_q;

  always_comb begin
    out_d = out_q;
    dir_d = dir_q;
    if (start) begin
      out_d = '0;
      dir_d = '0;
    end else if (en_i) begin
      if (out_we_i) out_d = N_PINS'(mask_merge(32'(out_q), 32'(out_wdata_i), 32'(out_wmask_i)));
      if (dir_we_i) dir_d = N_PINS'(mask_merge(32'(dir_q), 32'(dir_wdata_i), 32'(dir_wmask_i)));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      out_q <= '0;
      dir_q <= '0;
    end else begin
      en_q  <= en_i;
      out_q <= out_d;
      dir_q <= dir_d;
    end
  end

  // next-state view so the registered pins lag inputs by exactly one clock
  assign oe_nxt_o  = en_i ? dir_d : '0;
  assign val_nxt_o = (out_d | aux_i) & oe_nxt_o;
  assign out_q_o   = out_q;

  // R9
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !en_q) |=> (out_q == '0 && dir_q == '0));
  // R8
  dis_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(out_q));
  // R2
  mask_keeps_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_q && out_we_i) |=> (((out_q ^ $past(out_q)) & ~$past(out_wmask_i)) == '0));
endmodule

// File: rtl/gpio_wor_merge.sv
module gpio_wor_merge #(
  parameter int N_CORES = 8,
  parameter int N_PINS  = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_CORES-1:0][N_PINS-1:0] oe_vec_i,
  input  logic [N_CORES-1:0][N_PINS-1:0] val_vec_i,
  output logic [N_PINS-1:0]              pin_oe_o,
  output logic [N_PINS-1:0]              pin_val_o
);
  logic [N_PINS-1:0] oe_or, val_or;

  always_comb begin
    oe_or  = '0;
    val_or = '0;
    for (int c = 0; c < N_CORES; c++) begin
      oe_or  |= oe_vec_i[c];
      val_or |= val_vec_i[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_oe_o  <= '0;
      pin_val_o <= '0;
    end else begin
      pin_oe_o  <= oe_or;
      pin_val_o <= val_or;
    end
  end

  // R5
  val_within_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_val_o & ~pin_oe_o) == '0);
endmodule

// File: rtl/gpio_wor_combiner.sv
module gpio_wor_combiner #(
  parameter int N_CORES = 8,
  parameter int N_PINS  = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_CORES-1:0]             core_en_i,
  input  logic [N_CORES-1:0]             out_we_i,
  input  logic [N_CORES-1:0][N_PINS-1:0] out_wdata_i,
  input  logic [N_CORES-1:0][N_PINS-1:0] out_wmask_i,
  input  logic [N_CORES-1:0]             dir_we_i,
  input  logic [N_CORES-1:0][N_PINS-1:0] dir_wdata_i,
  input  logic [N_CORES-1:0][N_PINS-1:0] dir_wmask_i,
  input  logic [N_CORES-1:0][N_PINS-1:0] aux_out_i,
  output logic [N_CORES-1:0][N_PINS-1:0] out_rdata_o,
  output logic [N_PINS-1:0]              pin_oe_o,
  output logic [N_PINS-1:0]              pin_val_o
);
  logic [N_CORES-1:0][N_PINS-1:0] oe_nxt, val_nxt;

  for (genvar c = 0; c < N_CORES; c++) begin : g_slot
    gpio_core_slot #(.N_PINS(N_PINS)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (core_en_i[c]),
      .out_we_i   (out_we_i[c]),
      .out_wdata_i(out_wdata_i[c]),
      .out_wmask_i(out_wmask_i[c]),
      .dir_we_i   (dir_we_i[c]),
      .dir_wdata_i(dir_wdata_i[c]),
      .dir_wmask_i(dir_wmask_i[c]),
      .aux_i      (aux_out_i[c]),
      .out_q_o    (out_rdata_o[c]),
      .oe_nxt_o   (oe_nxt[c]),
      .val_nxt_o  (val_nxt[c])
    );
  end

  gpio_wor_merge #(.N_CORES(N_CORES), .N_PINS(N_PINS)) u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .oe_vec_i (oe_nxt),
    .val_vec_i(val_nxt),
    .pin_oe_o (pin_oe_o),
    .pin_val_o(pin_val_o)
  );

  // R7
  all_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_en_i == '0) |=> (pin_oe_o == '0 && pin_val_o == '0));
endmodule

// File: tb/gpio_wor_combiner_tb.sv
`timescale 1ns/1ps
module gpio_wor_combiner_tb_top;
  localparam int NC = 8;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] en, owe, dwe;
  logic [NC-1:0][NP-1:0] owd, owm, dwd, dwm, aux, rdata;
  logic [NP-1:0] pin_oe, pin_val;

  logic [NC-1:0][NP-1:0] m_out, m_dir;
  logic [NC-1:0] m_en_q;
  logic [NP-1:0] e_oe, e_val;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  gpio_wor_combiner #(.N_CORES(NC), .N_PINS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .core_en_i(en),
    .out_we_i(owe), .out_wdata_i(owd), .out_wmask_i(owm),
    .dir_we_i(dwe), .dir_wdata_i(dwd), .dir_wmask_i(dwm),
    .aux_out_i(aux), .out_rdata_o(rdata),
    .pin_oe_o(pin_oe), .pin_val_o(pin_val));

  task automatic chk(input string req, input string what, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // model update from current inputs; predicts the post-edge state
  task automatic predict();
    logic [NP-1:0] g;
    e_oe = '0; e_val = '0;
    for (int c = 0; c < NC; c++) begin
      if (en[c] && !m_en_q[c]) begin
        m_out[c] = '0; m_dir[c] = '0;
      end else if (en[c]) begin
        if (owe[c]) m_out[c] = (m_out[c] & ~owm[c]) | (owd[c] & owm[c]);
        if (dwe[c]) m_dir[c] = (m_dir[c] & ~dwm[c]) | (dwd[c] & dwm[c]);
      end
      m_en_q[c] = en[c];
      g = en[c] ? m_dir[c] : '0;
      e_oe  |= g;
      e_val |= (m_out[c] | aux[c]) & g;
    end
  endtask

  task automatic step(input string req);
    predict();
    @(posedge clk); #1;
    chk(req, "pin_oe", pin_oe, e_oe);
    chk(req, "pin_val", pin_val, e_val);
    for (int c = 0; c < NC; c++) chk(req, "rdata", rdata[c], m_out[c]);
    @(negedge clk);
    owe = '0; dwe = '0;
  endtask

  task automatic clear_in();
    en = '0; owe = '0; dwe = '0;
    owd = '0; owm = '0; dwd = '0; dwm = '0; aux = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clear_in();
    m_out = '0; m_dir = '0; m_en_q = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pin_oe", pin_oe, '0);
    chk("R1", "pin_val", pin_val, '0);
    for (int c = 0; c < NC; c++) chk("R1", "rdata", rdata[c], '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 start with a write in the same cycle: write dropped
    en[0] = 1'b1; owe[0] = 1'b1; owd[0] = '1; owm[0] = '1;
    dwe[0] = 1'b1; dwd[0] = '1; dwm[0] = '1;
    step("R9");
    chk("R9", "core0 latch", rdata[0], 32'h0);

    // R2 masked latch writes
    owe[0] = 1'b1; owd[0] = 32'hA5A5_A5A5; owm[0] = 32'h0000_00FF;
    step("R2");
    chk("R2", "low byte", rdata[0], 32'h0000_00A5);
    owe[0] = 1'b1; owd[0] = 32'h1234_5678; owm[0] = 32'h0000_FF00;
    step("R2");
    chk("R2", "second byte", rdata[0], 32'h0000_56A5);

    // R3 / R5 / R10 direction gates the latch; pins change one clock after write
    dwe[0] = 1'b1; dwd[0] = 32'h0000_000F; dwm[0] = '1;
    step("R10");
    chk("R3", "oe", pin_oe, 32'h0000_000F);
    chk("R5", "gated val", pin_val, 32'h0000_0005);

    // R4 aux reaches pins but not readback
    aux[0] = 32'hFFFF_0000;
    dwe[0] = 1'b1; dwd[0] = 32'h000F_0000; dwm[0] = 32'hFFFF_0000;
    step("R4");
    chk("R4", "readback", rdata[0], 32'h0000_56A5);
    chk("R5", "aux val", pin_val, 32'h000F_0005);

    // R6 second core overlaps on the same pins
    en[1] = 1'b1;
    step("R9");
    owe[1] = 1'b1; owd[1] = 32'h0000_00F0; owm[1] = '1;
    dwe[1] = 1'b1; dwd[1] = 32'h0000_00FF; dwm[1] = '1;
    step("R6");
    chk("R6", "oe or", pin_oe, 32'h000F_00FF);
    chk("R6", "val or", pin_val, 32'h000F_00F5);

    // R7 / R8 disable core1, then attempt writes while disabled
    en[1] = 1'b0;
    step("R7");
    chk("R7", "oe", pin_oe, 32'h000F_000F);
    chk("R7", "val", pin_val, 32'h000F_0005);
    owe[1] = 1'b1; owd[1] = '0; owm[1] = '1;
    aux[1] = '1;
    step("R8");
    chk("R8", "latch kept", rdata[1], 32'h0000_00F0);
    chk("R7", "aux ignored", pin_val, 32'h000F_0005);
    // R9 restart clears
    en[1] = 1'b1;
    step("R9");
    chk("R9", "restart latch", rdata[1], 32'h0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < NC; c++) begin
        if (($urandom % 16) == 0) en[c] = ~en[c];
        owe[c] = $urandom % 2; dwe[c] = ($urandom % 4) == 0;
        owd[c] = $urandom; owm[c] = $urandom;
        dwd[c] = $urandom; dwm[c] = $urandom & $urandom;
        aux[c] = $urandom & $urandom & $urandom;
      end
      step("R6");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule